// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds a parameterized bank of interrupt sources and decides when each one asks to be presented to an interrupt presenter. Each source is either a message-style source or a level-sensitive source. A message-style source reacts to the rising edge of its input. A level-sensitive source follows the level of its input. Per source the block stores a target server number, a priority, a saved priority and a small set of status bits. The type of each source is fixed by the `LEVEL_MASK` parameter (bit i set = source i is level-sensitive).

A priority of 0xFF masks a source. Message sources remember three things for later replay: an edge that arrived while masked, an edge that the presenter refused, and an event that is waiting for the output. Level sources remember whether their input is asserted and whether a presentation is outstanding. The presenter talks back with three strobes: reject, end-of-interrupt and resend. Reject and end-of-interrupt carry a global source number, which is the local index plus the `BASE_NUM` offset. Numbers outside the bank are ignored.

Requests leave through one valid/ready stream, one request per transfer. A request carries the global number, the server and the priority. Once `req_valid` is high, the request and its fields hold steady until `req_ready` is sampled high. When several sources are eligible at once, a round-robin pick chooses the next one to load. A source that is not chosen stays eligible. Configuration writes, reject, end-of-interrupt and resend are plain strobes and are always accepted. A query port reads back the stored configuration of one source.

Top module: `irq_src_ctrl`

## Requirements
- R1: After reset, no request is pending, and every source reads back server 0, priority 0xFF and saved priority 0xFF. This holds even for level sources whose input is already high.
- R2: A rising edge on a message source with priority other than 0xFF produces exactly one request. The request carries number BASE_NUM+index and the stored server and priority. It appears two clock edges after the edge is sampled.
- R3: A rising edge on a message source with priority 0xFF produces no request. A later configuration write with priority other than 0xFF releases exactly one request at the new server and priority.
- R4: A level source whose input is high and whose priority is not 0xFF produces one request. It produces no further request while that presentation is outstanding.
- R5: An end-of-interrupt naming a level source ends its outstanding presentation, so the source requests again if its input is still high. An end-of-interrupt naming a message source has no effect.
- R6: A reject naming a level source ends its outstanding presentation, so the source requests again. A reject naming a message source makes no request until a resend strobe, which then replays it once.
- R7: A resend finds a rejected message source at priority 0xFF. It drops the rejection without a request, and neither a later unmasking write nor a later resend replays it.
- R8: While req_valid is high and req_ready is low, req_valid, req_num, req_server and req_prio stay unchanged.
- R9: When several sources are eligible together, each is presented exactly once, one per transfer, and none is lost.
- R10: A reject or end-of-interrupt whose number lies outside BASE_NUM to BASE_NUM+NUM_SRC-1 changes nothing.
- R11: A level source held high at priority 0xFF requests nothing. A configuration write that unmasks it causes one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | NUM_SRC | Per-source interrupt input (edge for message, level for level-sensitive) |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_server | input | SERVER_W | New target server |
| cfg_prio | input | 8 | New priority (0xFF masks) |
| cfg_saved | input | 8 | New saved priority |
| qry_idx | input | IDX_W | Local index read back |
| qry_server | output | SERVER_W | Stored server of qry_idx |
| qry_prio | output | 8 | Stored priority of qry_idx |
| qry_saved | output | 8 | Stored saved priority of qry_idx |
| rej_valid | input | 1 | Reject strobe from the presenter |
| rej_num | input | GNUM_W | Global number being rejected |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | GNUM_W | Global number being ended |
| resend | input | 1 | Replay strobe for rejected message sources |
| req_valid | output | 1 | Request stream valid |
| req_ready | input | 1 | Request stream ready |
| req_num | output | GNUM_W | Global source number of the request |
| req_server | output | SERVER_W | Server of the request |
| req_prio | output | 8 | Priority of the request |

## Verification
The assertions assume the presenter only sees requests built from unmasked sources. They also assume the base offset plus the bank size fits in GNUM_W bits. The stimulus writes configuration, reject and end-of-interrupt strobes for one cycle each, and never two in the same cycle. Edges are single-cycle pulses spaced far apart, so no rise coincides with a configuration write to the same source. Back-pressure is applied only by holding req_ready low for whole stretches, which keeps the hold rule of the stream observable.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  localparam int PRIO_W = 8;
  localparam logic [PRIO_W-1:0] PRIO_OFF = 8'hFF;

  // Per-source status; `asserted` doubles as the previous input sample.
  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
    logic held;
  } src_stat_t;
endpackage

// File: rtl/irq_num_dec.sv
module irq_num_dec #(
  parameter int NUM_SRC  = 8,
  parameter int GNUM_W   = 12,
  parameter int BASE_NUM = 16
) (
  input  logic              valid,
  input  logic [GNUM_W-1:0] num,
  output logic [NUM_SRC-1:0] hit
);
  localparam logic [GNUM_W-1:0] LO = GNUM_W'(BASE_NUM);
  localparam logic [GNUM_W-1:0] HI = GNUM_W'(BASE_NUM + NUM_SRC);

  logic              in_bank;
  logic [GNUM_W-1:0] local_num;

  assign in_bank   = valid && (num >= LO) && (num < HI);
  assign local_num = num - LO;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign hit[i] = in_bank && (local_num == GNUM_W'(i));
  end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_src_pkg::*;
#(
  parameter int SERVER_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                is_level,
  input  logic                src_in,
  input  logic                cfg_we,
  input  logic [SERVER_W-1:0] cfg_server,
  input  logic [PRIO_W-1:0]   cfg_prio,
  input  logic [PRIO_W-1:0]   cfg_saved,
  input  logic                rej_hit,
  input  logic                eoi_hit,
  input  logic                resend,
  input  logic                take,
  output logic                eligible,
  output logic [SERVER_W-1:0] server,
  output logic [PRIO_W-1:0]   prio,
  output logic [PRIO_W-1:0]   saved
);
  src_stat_t stat, stat_n;
  logic      rise;
  logic      unmasked;

  assign rise     = src_in && !stat.asserted;
  assign unmasked = (prio != PRIO_OFF);

  always_comb begin
    stat_n = stat;
    stat_n.asserted = src_in;
    if (is_level) begin
      if (rej_hit || eoi_hit) stat_n.sent = 1'b0;
      if (take)               stat_n.sent = 1'b1;
    end else begin
      if (take) stat_n.held = 1'b0;
      if (rise) begin
        if (unmasked) stat_n.held  = 1'b1;
        else          stat_n.mpend = 1'b1;
      end
      if (cfg_we && stat.mpend && (cfg_prio != PRIO_OFF)) begin
        stat_n.mpend = 1'b0;
        stat_n.held  = 1'b1;
      end
      if (resend && stat.rejected) begin
        stat_n.rejected = 1'b0;
        if (unmasked) stat_n.held = 1'b1;
      end
      if (rej_hit) stat_n.rejected = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat   <= '0;
      server <= '0;
      prio   <= PRIO_OFF;
      saved  <= PRIO_OFF;
    end else begin
      stat <= stat_n;
      if (cfg_we) begin
        server <= cfg_server;
        prio   <= cfg_prio;
        saved  <= cfg_saved;
      end
    end
  end

  assign eligible = unmasked &&
                    (is_level ? (stat.asserted && !stat.sent) : stat.held);
endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req,
  input  logic               adv,
  output logic               any,
  output logic [IDX_W-1:0]   idx
);
  logic [IDX_W-1:0] ptr;

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = NUM_SRC - 1; k >= 0; k--) begin
      if (req[(int'(ptr) + k) % NUM_SRC]) begin
        any = 1'b1;
        idx = IDX_W'((int'(ptr) + k) % NUM_SRC);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (adv && any) begin
      ptr <= (int'(idx) == NUM_SRC - 1) ? '0 : idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/irq_req_slot.sv
module irq_req_slot
  import irq_src_pkg::*;
#(
  parameter int GNUM_W   = 12,
  parameter int SERVER_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [GNUM_W-1:0]   in_num,
  input  logic [SERVER_W-1:0] in_server,
  input  logic [PRIO_W-1:0]   in_prio,
  output logic                space,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [GNUM_W-1:0]   out_num,
  output logic [SERVER_W-1:0] out_server,
  output logic [PRIO_W-1:0]   out_prio
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_num    <= '0;
      out_server <= '0;
      out_prio   <= PRIO_OFF;
    end else if (load) begin
      out_valid  <= 1'b1;
      out_num    <= in_num;
      out_server <= in_server;
      out_prio   <= in_prio;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_src_ctrl.sv
module irq_src_ctrl
  import irq_src_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int SERVER_W   = 4,
  parameter int GNUM_W     = 12,
  parameter int BASE_NUM   = 16,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
  localparam int IDX_W     = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_in,
  input  logic                cfg_valid,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [SERVER_W-1:0] cfg_server,
  input  logic [7:0]          cfg_prio,
  input  logic [7:0]          cfg_saved,
  input  logic [IDX_W-1:0]    qry_idx,
  output logic [SERVER_W-1:0] qry_server,
  output logic [7:0]          qry_prio,
  output logic [7:0]          qry_saved,
  input  logic                rej_valid,
  input  logic [GNUM_W-1:0]   rej_num,
  input  logic                eoi_valid,
  input  logic [GNUM_W-1:0]   eoi_num,
  input  logic                resend,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [GNUM_W-1:0]   req_num,
  output logic [SERVER_W-1:0] req_server,
  output logic [7:0]          req_prio
);
  localparam logic [GNUM_W-1:0] BASE_G = GNUM_W'(BASE_NUM);

  logic [NUM_SRC-1:0]  rej_hit, eoi_hit, elig, take;
  logic [SERVER_W-1:0] srv_arr  [NUM_SRC];
  logic [PRIO_W-1:0]   prio_arr [NUM_SRC];
  logic [PRIO_W-1:0]   sav_arr  [NUM_SRC];
  logic                pick_any, slot_space, load;
  logic [IDX_W-1:0]    pick_idx;

  irq_num_dec #(.NUM_SRC(NUM_SRC), .GNUM_W(GNUM_W), .BASE_NUM(BASE_NUM)) u_rej_dec (
    .valid(rej_valid), .num(rej_num), .hit(rej_hit)
  );

  irq_num_dec #(.NUM_SRC(NUM_SRC), .GNUM_W(GNUM_W), .BASE_NUM(BASE_NUM)) u_eoi_dec (
    .valid(eoi_valid), .num(eoi_num), .hit(eoi_hit)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign take[i] = load && (pick_idx == IDX_W'(i));

    irq_src_cell #(.SERVER_W(SERVER_W)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_level   (LEVEL_MASK[i]),
      .src_in     (src_in[i]),
      .cfg_we     (cfg_valid && (cfg_idx == IDX_W'(i))),
      .cfg_server (cfg_server),
      .cfg_prio   (cfg_prio),
      .cfg_saved  (cfg_saved),
      .rej_hit    (rej_hit[i]),
      .eoi_hit    (eoi_hit[i]),
      .resend     (resend),
      .take       (take[i]),
      .eligible   (elig[i]),
      .server     (srv_arr[i]),
      .prio       (prio_arr[i]),
      .saved      (sav_arr[i])
    );
  end

  irq_rr_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .adv   (slot_space),
    .any   (pick_any),
    .idx   (pick_idx)
  );

  assign load = pick_any && slot_space;

  irq_req_slot #(.GNUM_W(GNUM_W), .SERVER_W(SERVER_W)) u_slot (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .in_num     (BASE_G + GNUM_W'(pick_idx)),
    .in_server  (srv_arr[pick_idx]),
    .in_prio    (prio_arr[pick_idx]),
    .space      (slot_space),
    .out_valid  (req_valid),
    .out_ready  (req_ready),
    .out_num    (req_num),
    .out_server (req_server),
    .out_prio   (req_prio)
  );

  assign qry_server = srv_arr[qry_idx];
  assign qry_prio   = prio_arr[qry_idx];
  assign qry_saved  = sav_arr[qry_idx];
endmodule

// File: rtl/irq_src_ctrl_chk.sv
module irq_src_ctrl_chk #(
  parameter int NUM_SRC  = 8,
  parameter int SERVER_W = 4,
  parameter int GNUM_W   = 12,
  parameter int BASE_NUM = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [GNUM_W-1:0]   req_num,
  input logic [SERVER_W-1:0] req_server,
  input logic [7:0]          req_prio,
  input logic [7:0]          qry_prio
);
  localparam logic [GNUM_W-1:0] LO = GNUM_W'(BASE_NUM);
  localparam logic [GNUM_W-1:0] HI = GNUM_W'(BASE_NUM + NUM_SRC);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!req_valid && qry_prio == 8'hFF));

  p_num_in_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_num >= LO && req_num < HI));

  p_no_masked_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_prio != 8'hFF));

  p_hold_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);

  p_hold_fields_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      ($stable(req_num) && $stable(req_server) && $stable(req_prio)));
endmodule

bind irq_src_ctrl irq_src_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .SERVER_W(SERVER_W), .GNUM_W(GNUM_W), .BASE_NUM(BASE_NUM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_num(req_num), .req_server(req_server), .req_prio(req_prio),
  .qry_prio(qry_prio)
);

// File: tb/irq_src_ctrl_bench.sv
module irq_src_ctrl_bench;
  localparam int N = 4, SW = 3, GW = 8, BASE = 32;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] src_in;
  logic cfg_valid;
  logic [1:0] cfg_idx, qry_idx;
  logic [SW-1:0] cfg_server, qry_server, req_server;
  logic [7:0] cfg_prio, cfg_saved, qry_prio, qry_saved, req_prio;
  logic rej_valid, eoi_valid, resend, req_valid, req_ready;
  logic [GW-1:0] rej_num, eoi_num, req_num;

  int n_chk = 0, n_bad = 0, fires = 0;
  int log_num [0:63];
  int last_num, last_srv, last_prio;
  bit done = 0;

  always #5 clk = ~clk;

  irq_src_ctrl #(.NUM_SRC(N), .SERVER_W(SW), .GNUM_W(GW), .BASE_NUM(BASE),
                 .LEVEL_MASK(4'b1100)) u_irq_src_ctrl (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .cfg_valid(cfg_valid),
    .cfg_idx(cfg_idx), .cfg_server(cfg_server), .cfg_prio(cfg_prio),
    .cfg_saved(cfg_saved), .qry_idx(qry_idx), .qry_server(qry_server),
    .qry_prio(qry_prio), .qry_saved(qry_saved), .rej_valid(rej_valid),
    .rej_num(rej_num), .eoi_valid(eoi_valid), .eoi_num(eoi_num),
    .resend(resend), .req_valid(req_valid), .req_ready(req_ready),
    .req_num(req_num), .req_server(req_server), .req_prio(req_prio)
  );

  // Transfers are observed mid-cycle; the handshake completes at the next edge.
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (fires < 64) log_num[fires] = int'(req_num);
      fires++;
      last_num = int'(req_num); last_srv = int'(req_server); last_prio = int'(req_prio);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int idx, input int srv, input int pr, input int sv);
    cfg_valid = 1; cfg_idx = 2'(idx); cfg_server = SW'(srv);
    cfg_prio = 8'(pr); cfg_saved = 8'(sv);
    step(1);
    cfg_valid = 0;
  endtask

  task automatic pulse(input int i);
    src_in[i] = 1'b1; step(1); src_in[i] = 1'b0;
  endtask

  task automatic rej(input int num);
    rej_valid = 1; rej_num = GW'(num); step(1); rej_valid = 0;
  endtask

  task automatic eoi(input int num);
    eoi_valid = 1; eoi_num = GW'(num); step(1); eoi_valid = 0;
  endtask

  task automatic do_resend();
    resend = 1; step(1); resend = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int c0, mask;
    int prios [3] = '{0, 5, 254};
    rst_n = 0; src_in = '0; cfg_valid = 0; cfg_idx = 0; cfg_server = 0;
    cfg_prio = 0; cfg_saved = 0; qry_idx = 0; rej_valid = 0; rej_num = 0;
    eoi_valid = 0; eoi_num = 0; resend = 0; req_ready = 1;
    step(3);
    src_in[3] = 1'b1;
    rst_n = 1;
    step(1);

    // R1: reset state of every source and of the stream
    chk("R1 req_valid", int'(req_valid), 0);
    for (int i = 0; i < N; i++) begin
      qry_idx = 2'(i); #1;
      chk("R1 server", int'(qry_server), 0);
      chk("R1 prio", int'(qry_prio), 255);
      chk("R1 saved", int'(qry_saved), 255);
    end
    step(4);
    chk("R1 no fire with level high", fires, 0);
    src_in[3] = 1'b0;
    step(2);

    // R2: sweep message sources over priorities
    for (int i = 0; i < 2; i++) begin
      for (int p = 0; p < 3; p++) begin
        int srv = (i * 3 + p) % 8;
        c0 = fires;
        cfg(i, srv, prios[p], prios[p] ^ 15);
        qry_idx = 2'(i); #1;
        chk("R2 saved readback", int'(qry_saved), prios[p] ^ 15);
        pulse(i);
        step(4);
        chk("R2 count", fires, c0 + 1);
        chk("R2 num", last_num, BASE + i);
        chk("R2 server", last_srv, srv);
        chk("R2 prio", last_prio, prios[p]);
      end
    end

    // R3: masked edge held, unmasking write releases it
    cfg(0, 1, 255, 255);
    c0 = fires;
    pulse(0);
    step(4);
    chk("R3 masked no fire", fires, c0);
    cfg(0, 5, 3, 9);
    step(4);
    chk("R3 unmask count", fires, c0 + 1);
    chk("R3 num", last_num, BASE);
    chk("R3 server", last_srv, 5);
    chk("R3 prio", last_prio, 3);

    // R4: level source presents once
    cfg(2, 2, 4, 4);
    c0 = fires;
    src_in[2] = 1'b1;
    step(8);
    chk("R4 single fire", fires, c0 + 1);
    chk("R4 num", last_num, BASE + 2);
    chk("R4 prio", last_prio, 4);

    // R5: EOI on level re-presents, EOI on message does nothing
    c0 = fires;
    eoi(BASE + 2);
    step(4);
    chk("R5 level eoi refire", fires, c0 + 1);
    chk("R5 num", last_num, BASE + 2);
    c0 = fires;
    eoi(BASE + 0);
    step(4);
    chk("R5 message eoi no effect", fires, c0);

    // R6: reject on level re-presents; reject on message waits for resend
    c0 = fires;
    rej(BASE + 2);
    step(4);
    chk("R6 level reject refire", fires, c0 + 1);
    c0 = fires;
    rej(BASE + 1);
    step(4);
    chk("R6 message reject quiet", fires, c0);
    do_resend();
    step(4);
    chk("R6 resend count", fires, c0 + 1);
    chk("R6 resend num", last_num, BASE + 1);
    chk("R6 resend prio", last_prio, 254);
    c0 = fires;
    do_resend();
    step(4);
    chk("R6 second resend no replay", fires, c0);

    // R7: resend of a masked rejected message source drops the rejection
    rej(BASE + 1);
    cfg(1, 4, 255, 255);
    c0 = fires;
    do_resend();
    step(3);
    cfg(1, 4, 2, 2);
    step(4);
    chk("R7 unmask no replay", fires, c0);
    do_resend();
    step(4);
    chk("R7 resend no replay", fires, c0);

    // R10: out-of-range reject / EOI leave the outstanding level source alone
    c0 = fires;
    rej(BASE + N);
    eoi(BASE - 1);
    eoi(BASE + N + 3);
    step(4);
    chk("R10 out of range ignored", fires, c0);
    eoi(BASE + 2);
    step(4);
    chk("R10 in range still works", fires, c0 + 1);

    // R8: back-pressure holds the request
    req_ready = 0;
    c0 = fires;
    pulse(0);
    step(4);
    chk("R8 valid", int'(req_valid), 1);
    chk("R8 num", int'(req_num), BASE);
    step(5);
    chk("R8 valid held", int'(req_valid), 1);
    chk("R8 num held", int'(req_num), BASE);
    chk("R8 server held", int'(req_server), 5);
    chk("R8 prio held", int'(req_prio), 3);
    req_ready = 1;
    step(3);
    chk("R8 single transfer", fires, c0 + 1);
    chk("R8 idle after", int'(req_valid), 0);

    // R11: masked level source stays quiet until unmasked
    src_in[2] = 1'b0;
    eoi(BASE + 2);
    step(3);
    req_ready = 0;
    src_in[3] = 1'b1;
    step(5);
    chk("R11 masked level quiet", int'(req_valid), 0);
    cfg(3, 1, 6, 6);
    step(3);
    chk("R11 unmask valid", int'(req_valid), 1);
    chk("R11 unmask num", int'(req_num), BASE + 3);

    // R9: four sources eligible together
    c0 = fires;
    pulse(0);
    pulse(1);
    src_in[2] = 1'b1;
    step(4);
    req_ready = 1;
    step(10);
    chk("R9 four transfers", fires, c0 + 4);
    mask = 0;
    for (int k = 0; k < 4; k++) mask |= 1 << (log_num[c0 + k] - BASE);
    chk("R9 all sources once", mask, 15);

    done = 1;
    summary();
  end
endmodule